// File: doc/BRIEF.md
# Command-List Dataway Transfer Executor

This block runs a single data-transfer entry taken from a command list kept in word memory. After a start pulse it reads the instruction word, the repeat count and one or more function/address codes (FCNA words) through a list-memory read port. It then issues each code on a request/acknowledge dataway port and collects the Q and X responses. Read data goes into a buffer memory and write data comes out of it, both through a word-address port. Q and X failures are counted in two separate counters.

Modifier bits in the instruction word choose several options. One chooses how the block waits for a look-at-me (LAM) signal. Another switches between repeating one code and walking a zero-terminated list of codes. Another chooses 24-bit transfers packed as two buffer words. The last chooses whether read data is added into the buffer or overwrites it; on a write entry it instead gives a pure skip of the buffer pointer. For reads and writes, the block first checks that the buffer has enough room and refuses the whole entry if it does not. List and buffer pointers follow a pre-increment convention: each holds one less than the next address to be used.

Top module: `clist_xfer`

## Requirements
- R1: If bit 15 of the instruction word is clear, the entry completes with status 1 (end of list) and no dataway request, and the list pointer rests on that word.
- R2: Bits 2:0 of the instruction give the opcode: 1 write, 2 read, 3 control. Any other opcode, a count of zero, or a write with bit 10 set together with bit 11 or bit 12, completes with status 3 (illegal) and no dataway request.
- R3: With bit 12 clear, the instruction is followed by a count N and then one FCNA word, and that code is issued N times.
- R4: With bit 12 set, the count N is followed by N different FCNA words, each issued once, and then a zero word. The final list pointer rests on that zero word.
- R5: With bit 13 set and bit 14 clear, the block waits for LAM before every code. With bit 14 set and bit 13 clear, it never waits. With both set, it waits once and then issues all codes back to back.
- R6: Both error counters clear when a command is accepted. Each code answered without Q adds one to the Q counter. If X is also false, the X counter adds one as well.
- R7: For read and write, the words needed are N, or 2N when bit 11 is set. If this exceeds the remaining buffer room, the entry completes with status 2 (overrun) before any dataway request, and the buffer contents, room and pointer are left unchanged.
- R8: With bit 11 set, each code moves two buffer words: the low 16 data bits first, then the upper 8 bits zero-extended. A write sends {second[7:0], first} as its 24-bit data.
- R9: With bit 10 set on a read, the 24-bit read value is added to the existing buffer contents. The low word is summed first, and its carry goes into the high word.
- R10: With bit 10 set on a write, no code is issued. The buffer pointer advances by N and the room drops by N.
- R11: Each buffer word uses the address one above the current buffer pointer, then advances the pointer by one and lowers the room by one. The outputs report the final values.
- R12: Start is ignored while a command is running. Done is a one-cycle pulse with status 0 on success. A dataway request holds its code stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted when idle |
| init_list_ptr | input | AW | List address of the instruction minus one |
| init_buf_ptr | input | AW | Buffer address of the first word minus one |
| init_buf_room | input | AW | Buffer words still free |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 end of list, 2 overrun, 3 illegal |
| list_ptr | output | AW | Current list pointer |
| buf_ptr | output | AW | Current buffer pointer |
| buf_room | output | AW | Current remaining room |
| q_errs | output | EW | Count of codes without Q |
| x_errs | output | EW | Count of codes without Q and X |
| lst_addr | output | AW | List memory read address |
| lst_rdata | input | 16 | List memory word (combinational read) |
| bm_addr | output | AW | Buffer memory address |
| bm_rdata | input | 16 | Buffer memory word (combinational read) |
| bm_wdata | output | 16 | Buffer write data |
| bm_we | output | 1 | Buffer write enable |
| dw_req | output | 1 | Dataway request |
| dw_fcna | output | 16 | Function/address code |
| dw_wdata | output | 24 | Dataway write data |
| dw_rdata | input | 24 | Dataway read data |
| dw_ack | input | 1 | Dataway acknowledge |
| dw_q | input | 1 | Q response, valid with acknowledge |
| dw_x | input | 1 | X response, valid with acknowledge |
| dw_lam | input | 1 | Look-at-me request |

## Verification
The dataway model derives its Q, X and read data from the bits of each code. That lets the bench tell apart a repeated single code from a walked list, and a correct Q/X split from swapped counters. Reads are tried in overwrite and add modes against preloaded words that produce a low-word carry, and in single- and double-word layouts. Writes are tried as real transfers and as pure pointer skips. The LAM policies are told apart by holding LAM low and then pulsing it one cycle at a time, while counting how many codes complete after each pulse. Room that fits exactly, room that is one word short, end-of-list words and each illegal form are each run on their own.

// File: rtl/clist_pkg.sv
package clist_pkg;
    localparam int WORD_W = 16;
    localparam int FCNA_W = 16;
    localparam int DATA_W = 24;

    typedef enum logic [3:0] {
        S_IDLE, S_INS, S_CNT, S_FCNA, S_LAM, S_BLO, S_BHI,
        S_CAM, S_WLO, S_WHI, S_TERM, S_DONE
    } state_e;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_END     = 2'd1,
        ST_OVERRUN = 2'd2,
        ST_BAD     = 2'd3
    } status_e;

    typedef struct packed {
        logic wr;
        logic rd;
        logic ctl;
        logic bad;
        logic dbl;
        logic add;
        logic skip;
        logic lst;
        logic wait_each;
        logic wait_once;
    } dec_t;
endpackage

// File: rtl/clist_decode.sv
module clist_decode
    import clist_pkg::*;
(
    input  logic [WORD_W-1:0] ins,
    output dec_t              dec
);
    logic [2:0] op;
    logic       unused_bits;

    assign op          = ins[2:0];
    assign unused_bits = ^{ins[15], ins[9:3]};

    always_comb begin
        dec.wr        = (op == 3'd1);
        dec.rd        = (op == 3'd2);
        dec.ctl       = (op == 3'd3);
        // R2: unknown opcode or forbidden skip combination
        dec.bad       = !(dec.wr || dec.rd || dec.ctl) ||
                        (dec.wr && ins[10] && (ins[11] || ins[12]));
        dec.dbl       = ins[11] && (dec.wr || dec.rd);
        dec.add       = ins[10] && dec.rd;
        dec.skip      = ins[10] && dec.wr;
        dec.lst       = ins[12];
        dec.wait_each = ins[13] && !ins[14];
        dec.wait_once = ins[13] && ins[14];
    end
endmodule

// File: rtl/clist_room.sv
module clist_room
    import clist_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [WORD_W-1:0] cnt,
    input  logic              dbl,
    input  logic [AW-1:0]     room,
    output logic              short_o
);
    localparam int NW = (WORD_W + 1 > AW) ? WORD_W + 1 : AW;

    logic [NW-1:0] need;
    logic [NW-1:0] have;

    always_comb begin
        need    = dbl ? (NW'(cnt) << 1) : NW'(cnt);
        have    = NW'(room);
        short_o = need > have;
    end
endmodule

// File: rtl/clist_errcnt.sv
module clist_errcnt #(
    parameter int EW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          ev,
    input  logic          q,
    input  logic          x,
    output logic [EW-1:0] q_cnt,
    output logic [EW-1:0] x_cnt
);
    typedef struct packed {
        logic [EW-1:0] qc;
        logic [EW-1:0] xc;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (ev && !q) begin
            cnt_d.qc = cnt_q.qc + EW'(1);
            if (!x) cnt_d.xc = cnt_q.xc + EW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign q_cnt = cnt_q.qc;
    assign x_cnt = cnt_q.xc;
endmodule

// File: rtl/clist_xfer.sv
module clist_xfer
    import clist_pkg::*;
#(
    parameter int AW = 16,
    parameter int EW = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [AW-1:0]       init_list_ptr,
    input  logic [AW-1:0]       init_buf_ptr,
    input  logic [AW-1:0]       init_buf_room,
    output logic                done,
    output logic [1:0]          status,
    output logic [AW-1:0]       list_ptr,
    output logic [AW-1:0]       buf_ptr,
    output logic [AW-1:0]       buf_room,
    output logic [EW-1:0]       q_errs,
    output logic [EW-1:0]       x_errs,
    output logic [AW-1:0]       lst_addr,
    input  logic [WORD_W-1:0]   lst_rdata,
    output logic [AW-1:0]       bm_addr,
    input  logic [WORD_W-1:0]   bm_rdata,
    output logic [WORD_W-1:0]   bm_wdata,
    output logic                bm_we,
    output logic                dw_req,
    output logic [FCNA_W-1:0]   dw_fcna,
    output logic [DATA_W-1:0]   dw_wdata,
    input  logic [DATA_W-1:0]   dw_rdata,
    input  logic                dw_ack,
    input  logic                dw_q,
    input  logic                dw_x,
    input  logic                dw_lam
);
    typedef struct packed {
        state_e              st;
        logic [AW-1:0]       lptr;
        logic [AW-1:0]       bptr;
        logic [AW-1:0]       room;
        logic [WORD_W-1:0]   ins;
        logic [WORD_W-1:0]   cnt;
        logic [FCNA_W-1:0]   fcna;
        logic [DATA_W-1:0]   data;
        logic                carry;
        logic                first;
        status_e             stat;
    } regs_t;

    regs_t r_q, r_d;
    dec_t  dec;
    logic  room_short;
    logic  cnt_clr;
    logic  ack_ev;

    clist_decode u_dec (
        .ins (r_q.ins),
        .dec (dec)
    );

    clist_room #(.AW(AW)) u_room (
        .cnt     (lst_rdata),
        .dbl     (dec.dbl),
        .room    (r_q.room),
        .short_o (room_short)
    );

    clist_errcnt #(.EW(EW)) u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .ev    (ack_ev),
        .q     (dw_q),
        .x     (dw_x),
        .q_cnt (q_errs),
        .x_cnt (x_errs)
    );

    state_e          xfer_st;
    state_e          after_st;
    logic [WORD_W:0] lo_sum;

    always_comb begin
        r_d      = r_q;
        cnt_clr  = 1'b0;
        ack_ev   = 1'b0;
        bm_we    = 1'b0;
        bm_wdata = '0;
        lo_sum   = {1'b0, bm_rdata} + {1'b0, r_q.data[15:0]};
        xfer_st  = dec.wr ? S_BLO : S_CAM;
        if (r_q.cnt == WORD_W'(1))
            after_st = dec.lst ? S_TERM : S_DONE;
        else if (dec.lst)
            after_st = S_FCNA;
        else
            after_st = dec.wait_each ? S_LAM : xfer_st;

        unique case (r_q.st)
            S_IDLE: begin
                if (start) begin
                    r_d.lptr = init_list_ptr;
                    r_d.bptr = init_buf_ptr;
                    r_d.room = init_buf_room;
                    r_d.stat = ST_OK;
                    cnt_clr  = 1'b1;
                    r_d.st   = S_INS;
                end
            end
            S_INS: begin
                r_d.lptr = r_q.lptr + AW'(1);
                r_d.ins  = lst_rdata;
                if (!lst_rdata[15]) begin
                    r_d.stat = ST_END;
                    r_d.st   = S_DONE;
                end else begin
                    r_d.st = S_CNT;
                end
            end
            S_CNT: begin
                r_d.lptr  = r_q.lptr + AW'(1);
                r_d.cnt   = lst_rdata;
                r_d.first = 1'b1;
                if (dec.bad || lst_rdata == '0) begin
                    r_d.stat = ST_BAD;
                    r_d.st   = S_DONE;
                end else if ((dec.wr || dec.rd) && room_short) begin
                    r_d.stat = ST_OVERRUN;
                    r_d.st   = S_DONE;
                end else if (dec.skip) begin
                    r_d.bptr = r_q.bptr + AW'(lst_rdata);
                    r_d.room = r_q.room - AW'(lst_rdata);
                    r_d.st   = S_DONE;
                end else begin
                    r_d.st = S_FCNA;
                end
            end
            S_FCNA: begin
                r_d.lptr = r_q.lptr + AW'(1);
                r_d.fcna = lst_rdata;
                r_d.st   = (dec.wait_each || (dec.wait_once && r_q.first)) ? S_LAM : xfer_st;
            end
            S_LAM: begin
                if (dw_lam) r_d.st = xfer_st;
            end
            S_BLO: begin
                r_d.bptr = r_q.bptr + AW'(1);
                r_d.room = r_q.room - AW'(1);
                r_d.data = {8'h00, bm_rdata};
                r_d.st   = dec.dbl ? S_BHI : S_CAM;
            end
            S_BHI: begin
                r_d.bptr       = r_q.bptr + AW'(1);
                r_d.room       = r_q.room - AW'(1);
                r_d.data[23:16] = bm_rdata[7:0];
                r_d.st         = S_CAM;
            end
            S_CAM: begin
                if (dw_ack) begin
                    ack_ev    = 1'b1;
                    r_d.first = 1'b0;
                    if (dec.rd) begin
                        r_d.data = dw_rdata;
                        r_d.st   = S_WLO;
                    end else begin
                        r_d.cnt = r_q.cnt - WORD_W'(1);
                        r_d.st  = after_st;
                    end
                end
            end
            S_WLO: begin
                bm_we     = 1'b1;
                bm_wdata  = dec.add ? lo_sum[WORD_W-1:0] : r_q.data[15:0];
                r_d.carry = dec.add && lo_sum[WORD_W];
                r_d.bptr  = r_q.bptr + AW'(1);
                r_d.room  = r_q.room - AW'(1);
                if (dec.dbl) begin
                    r_d.st = S_WHI;
                end else begin
                    r_d.cnt = r_q.cnt - WORD_W'(1);
                    r_d.st  = after_st;
                end
            end
            S_WHI: begin
                bm_we    = 1'b1;
                bm_wdata = dec.add ? (bm_rdata + {8'h00, r_q.data[23:16]} + {15'd0, r_q.carry})
                                   : {8'h00, r_q.data[23:16]};
                r_d.bptr = r_q.bptr + AW'(1);
                r_d.room = r_q.room - AW'(1);
                r_d.cnt  = r_q.cnt - WORD_W'(1);
                r_d.st   = after_st;
            end
            S_TERM: begin
                r_d.lptr = r_q.lptr + AW'(1);
                r_d.st   = S_DONE;
            end
            S_DONE: begin
                r_d.st = S_IDLE;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= S_IDLE;
            r_q.stat <= ST_OK;
        end else begin
            r_q <= r_d;
        end
    end

    assign done     = (r_q.st == S_DONE);
    assign status   = r_q.stat;
    assign list_ptr = r_q.lptr;
    assign buf_ptr  = r_q.bptr;
    assign buf_room = r_q.room;
    assign lst_addr = r_q.lptr + AW'(1);
    assign bm_addr  = r_q.bptr + AW'(1);
    assign dw_req   = (r_q.st == S_CAM);
    assign dw_fcna  = r_q.fcna;
    assign dw_wdata = r_q.data;
endmodule

// File: rtl/clist_xfer_chk.sv
module clist_xfer_chk #(
    parameter int AW = 16,
    parameter int EW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          done,
    input logic [AW-1:0] buf_room,
    input logic [EW-1:0] q_errs,
    input logic [EW-1:0] x_errs,
    input logic          bm_we,
    input logic          dw_req,
    input logic [15:0]   dw_fcna,
    input logic          dw_ack
);
    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dw_req && !dw_ack) |=> (dw_req && $stable(dw_fcna)));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    x_le_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
        x_errs <= q_errs);

    // R11
    room_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (buf_room <= $past(buf_room)));

    // R12
    we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bm_we |-> !dw_req);

    // R12
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !dw_req);
endmodule

bind clist_xfer clist_xfer_chk #(.AW(AW), .EW(EW)) u_chk (.*);

// File: tb/clist_xfer_tb.sv
module clist_xfer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int EW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] init_list_ptr = '0, init_buf_ptr = '0, init_buf_room = '0;
    logic          done;
    logic [1:0]    status;
    logic [AW-1:0] list_ptr, buf_ptr, buf_room, lst_addr, bm_addr;
    logic [EW-1:0] q_errs, x_errs;
    logic [15:0]   lst_rdata, bm_rdata, bm_wdata, dw_fcna;
    logic          bm_we, dw_req, dw_q, dw_x;
    logic          dw_ack = 1'b0;
    logic          dw_lam = 1'b0;
    logic [23:0]   dw_wdata, dw_rdata;

    logic [15:0] lmem [0:127];
    logic [15:0] bmem [0:63];
    int          ops = 0;
    logic [15:0] last_fcna = '0;
    logic [23:0] last_wd = '0;
    int          n_chk = 0;
    int          n_fail = 0;

    logic [1:0]    s_status;
    logic [AW-1:0] s_lptr, s_bptr, s_room;
    logic [EW-1:0] s_q, s_x;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [23:0] cam_val(input logic [15:0] f);
        return {f[7:0], ~f};
    endfunction

    assign lst_rdata = lmem[lst_addr[6:0]];
    assign bm_rdata  = bmem[bm_addr[5:0]];
    assign dw_q      = ~dw_fcna[14];
    assign dw_x      = ~dw_fcna[13];
    assign dw_rdata  = cam_val(dw_fcna);

    always @(posedge clk) if (bm_we) bmem[bm_addr[5:0]] <= bm_wdata;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dw_ack <= 1'b0;
        end else begin
            dw_ack <= dw_req && !dw_ack;
            if (dw_req && dw_ack) begin
                ops       <= ops + 1;
                last_fcna <= dw_fcna;
                last_wd   <= dw_wdata;
            end
        end
    end

    clist_xfer #(.AW(AW), .EW(EW)) u_dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic kick(input logic [15:0] lp, input logic [15:0] bp, input logic [15:0] rm);
        @(negedge clk);
        init_list_ptr = lp; init_buf_ptr = bp; init_buf_room = rm;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        bit got = 0;
        for (int i = 0; i < 400 && !got; i++) begin
            if (done) begin
                got = 1;
                s_status = status; s_lptr = list_ptr; s_bptr = buf_ptr;
                s_room = buf_room; s_q = q_errs; s_x = x_errs;
            end else begin
                @(negedge clk);
            end
        end
        if (!got) begin
            n_chk++; n_fail++;
            $display("FAIL R12: actual no done expected done");
        end
        @(negedge clk);
    endtask

    task automatic run(input logic [15:0] lp, input logic [15:0] bp, input logic [15:0] rm);
        kick(lp, bp, rm);
        wait_done();
    endtask

    task automatic t_reset();
        check("R12 reset done", {31'd0, done}, 32'd0);
        check("R12 reset req", {31'd0, dw_req}, 32'd0);
        check("R6 reset qerr", q_errs, 32'd0);
    endtask

    task automatic t_write();   // R3 R5 R8 R11
        int o;
        lmem[0] = 16'hC801; lmem[1] = 16'd2; lmem[2] = 16'h0021;
        bmem[10] = 16'h1111; bmem[11] = 16'h00AB; bmem[12] = 16'h2222; bmem[13] = 16'h00CD;
        o = ops;
        run(16'hFFFF, 16'd9, 16'd10);
        check("R3 write ops", ops - o, 32'd2);
        check("R3 write fcna", last_fcna, 32'h21);
        check("R8 write data", last_wd, 32'hCD2222);
        check("R11 write bptr", s_bptr, 32'd13);
        check("R11 write room", s_room, 32'd6);
        check("R5 fast status", s_status, 32'd0);
        check("R12 done pulse", {31'd0, done}, 32'd0);
    endtask

    task automatic t_readlist(); // R4 R8
        lmem[8] = 16'h9802; lmem[9] = 16'd2; lmem[10] = 16'h0005; lmem[11] = 16'h0006; lmem[12] = 16'h0;
        run(16'd7, 16'd19, 16'd4);
        check("R8 rd lo0", bmem[20], 32'hFFFA);
        check("R8 rd hi0", bmem[21], 32'h0005);
        check("R4 rd lo1", bmem[22], 32'hFFF9);
        check("R4 rd hi1", bmem[23], 32'h0006);
        check("R4 list ptr", s_lptr, 32'd12);
        check("R7 exact fit room", s_room, 32'd0);
    endtask

    task automatic t_add();      // R9
        lmem[16] = 16'hCC02; lmem[17] = 16'd1; lmem[18] = 16'h0001;
        bmem[30] = 16'h0003; bmem[31] = 16'h0010;
        run(16'd15, 16'd29, 16'd2);
        check("R9 add lo", bmem[30], 32'h0001);
        check("R9 add hi carry", bmem[31], 32'h0012);
    endtask

    task automatic t_overrun();  // R7
        int o;
        lmem[24] = 16'h8802; lmem[25] = 16'd2; lmem[26] = 16'h0002;
        bmem[40] = 16'hBEEF;
        o = ops;
        run(16'd23, 16'd39, 16'd3);
        check("R7 status", s_status, 32'd2);
        check("R7 no ops", ops - o, 32'd0);
        check("R7 buf kept", bmem[40], 32'hBEEF);
        check("R7 room kept", s_room, 32'd3);
        check("R7 bptr kept", s_bptr, 32'd39);
    endtask

    task automatic t_errs();     // R6
        int o;
        lmem[32] = 16'h9003; lmem[33] = 16'd3; lmem[34] = 16'h4001;
        lmem[35] = 16'h6002; lmem[36] = 16'h0003; lmem[37] = 16'h0;
        o = ops;
        run(16'd31, 16'd0, 16'd0);
        check("R6 q count", s_q, 32'd2);
        check("R6 x count", s_x, 32'd1);
        check("R6 ops", ops - o, 32'd3);
        lmem[38] = 16'h8003; lmem[39] = 16'd1; lmem[40] = 16'h0004;
        run(16'd37, 16'd0, 16'd0);
        check("R6 q cleared", s_q, 32'd0);
        check("R6 x cleared", s_x, 32'd0);
    endtask

    task automatic t_end();      // R1
        int o;
        lmem[42] = 16'h0002;
        o = ops;
        run(16'd41, 16'd0, 16'd5);
        check("R1 status", s_status, 32'd1);
        check("R1 ptr", s_lptr, 32'd42);
        check("R1 no ops", ops - o, 32'd0);
    endtask

    task automatic t_skip();     // R10
        int o;
        lmem[44] = 16'h8401; lmem[45] = 16'd5;
        o = ops;
        run(16'd43, 16'd50, 16'd8);
        check("R10 bptr", s_bptr, 32'd55);
        check("R10 room", s_room, 32'd3);
        check("R10 no ops", ops - o, 32'd0);
        check("R10 status", s_status, 32'd0);
    endtask

    task automatic t_bad();      // R2
        int o;
        o = ops;
        lmem[48] = 16'h8C01; lmem[49] = 16'd1; lmem[50] = 16'h0003;
        run(16'd47, 16'd0, 16'd9);
        check("R2 skip+dbl", s_status, 32'd3);
        lmem[52] = 16'h8002; lmem[53] = 16'd0; lmem[54] = 16'h0003;
        run(16'd51, 16'd0, 16'd9);
        check("R2 zero count", s_status, 32'd3);
        lmem[56] = 16'h8005; lmem[57] = 16'd1; lmem[58] = 16'h0003;
        run(16'd55, 16'd0, 16'd9);
        check("R2 bad opcode", s_status, 32'd3);
        check("R2 no ops", ops - o, 32'd0);
    endtask

    task automatic t_lam();      // R5 R12
        int o;
        lmem[60] = 16'hA003; lmem[61] = 16'd2; lmem[62] = 16'h0007;
        o = ops;
        kick(16'd59, 16'd0, 16'd0);
        repeat (10) @(negedge clk);
        check("R5 each no lam", ops - o, 32'd0);
        start = 1'b1; init_list_ptr = 16'd0;   // ignored while busy
        @(negedge clk); start = 1'b0;
        dw_lam = 1'b1; @(negedge clk); dw_lam = 1'b0;
        repeat (10) @(negedge clk);
        check("R5 each one pulse", ops - o, 32'd1);
        dw_lam = 1'b1; @(negedge clk); dw_lam = 1'b0;
        wait_done();
        check("R5 each total", ops - o, 32'd2);
        check("R12 start ignored", s_lptr, 32'd62);

        lmem[64] = 16'hE003; lmem[65] = 16'd3; lmem[66] = 16'h0007;
        o = ops;
        kick(16'd63, 16'd0, 16'd0);
        repeat (10) @(negedge clk);
        check("R5 once no lam", ops - o, 32'd0);
        dw_lam = 1'b1; @(negedge clk); dw_lam = 1'b0;
        wait_done();
        check("R5 once total", ops - o, 32'd3);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) lmem[i] = 16'h0;
        for (int i = 0; i < 64; i++) bmem[i] = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write();
        t_readlist();
        t_add();
        t_overrun();
        t_errs();
        t_end();
        t_skip();
        t_bad();
        t_lam();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL R12: actual watchdog expired expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule